// File: doc/BRIEF.md
# Host-Bus Access Strobe Sequencer

This block sequences the external pins of a single chip select on a 16-bit parallel host bus. An internal requester presents a read or write with an address, write data and a burst-continue flag. The block then drives the chip select, the address-latch-enable pulse, the shared or separate address and data lines, and the read or write strobe. It returns the read data together with a one-clock done pulse for each word it transfers.

Configuration inputs set the timing and the bus style. Two-bit wait-state fields select an active strobe width of 2, 4, 6 or 8 clocks, one field for reads and one for writes. A trim bit for each direction removes one clock from that width. A chip-select enable chooses between a chip-select-specific sub-mode and a global one. Three sub-modes are legal: multiplexed address/data, separate address and data lines, and continuous read, in which consecutive reads step the address while the read strobe stays asserted. A burst enable allows multi-word transfers in the multiplexed sub-mode. These use a single address phase and a fixed strobe width.

The sequencer is a five-state machine. IDLE waits for a request and takes it (IDLE to ADDR) unless the resolved sub-mode is illegal, in which case the machine stays in IDLE and flags an error. ADDR is the one-clock address phase. It moves to TURN in the multiplexed sub-mode and straight to STRB otherwise. TURN is the one-clock bus turnaround and always moves to STRB. STRB holds the active strobe for its width. At its last clock it goes to BGAP to continue a burst, stays in STRB to continue a continuous read, or returns to IDLE to finish. BGAP is the one-clock gap between burst words and always moves back to STRB.

Top module: `hb_strobe_seq`

## Requirements
- R1: After reset, bus_cs, bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_done and rsp_err are all low.
- R2: A read strobe (bus_rd high) lasts 2*(cfg_rd_ws+1) clocks, which is 2, 4, 6 or 8 for encodings 0 to 3, minus one clock when cfg_rd_trim is 1.
- R3: A write strobe (bus_wr high) lasts 2*(cfg_wr_ws+1) clocks minus one when cfg_wr_trim is 1. bus_ad_out carries the write data while bus_wr is high.
- R4: In sub-mode 0 (multiplexed), the access runs as follows. The first clock after acceptance is the address phase: bus_ale is high for exactly that one clock and bus_ad_out shows the address. One turnaround clock follows. The strobe then starts, and the first rsp_done comes W+3 clocks after the request clock, where W is the strobe width.
- R5: In sub-mode 1 (separate), bus_ale stays low and bus_addr carries the address while bus_cs is high. The strobe follows the one-clock address phase directly, with no turnaround, so rsp_done comes W+2 clocks after the request clock. The wait-state setting changes only W.
- R6: Read data on bus_ad_in is sampled on the last clock of each word's strobe. It appears on rsp_rdata in the clock after that, together with a one-clock rsp_done.
- R7: In sub-mode 2, a read with req_burst high at the last strobe clock continues with bus_rd held high and bus_addr incremented by one, for another W clocks. Each word gives one rsp_done. Writes and single reads in sub-mode 2 behave as in sub-mode 1.
- R8: Sub-mode 3 is illegal. Such a request asserts no bus_cs and no strobe, and rsp_err pulses for one clock in the clock after the request clock.
- R9: With cfg_burst_en set in sub-mode 0, a request gives one address phase and then one strobe of BURST_STB clocks (2 by default) per word, whatever the wait-state and trim values. Words are separated by a one-clock gap that carries rsp_done. Write data for the next word is sampled from req_wdata during that gap. The burst ends when req_burst is low at a word's last strobe clock. cfg_burst_en has no effect in sub-modes 1 and 2.
- R10: When cfg_cs_sel is 0 the sub-mode comes from cfg_glb_mode; when 1 it comes from cfg_cs_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst-continue: another word follows |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data (first word, then each burst word) |
| cfg_cs_sel | input | 1 | Use the chip-select sub-mode instead of the global one |
| cfg_cs_mode | input | 2 | Chip-select sub-mode (0 mux, 1 separate, 2 continuous read, 3 illegal) |
| cfg_glb_mode | input | 2 | Global sub-mode, same encoding |
| cfg_rd_ws | input | WS_BITS | Read wait-state encoding |
| cfg_wr_ws | input | WS_BITS | Write wait-state encoding |
| cfg_rd_trim | input | 1 | Shorten read strobe by one clock |
| cfg_wr_trim | input | 1 | Shorten write strobe by one clock |
| cfg_burst_en | input | 1 | Allow bursts in sub-mode 0 |
| bus_ad_in | input | DW | Data lines as driven by the device |
| bus_ad_out | output | DW | Address/data lines driven by the block |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_addr | output | AW | Separate address lines (sub-modes 1 and 2) |
| bus_ale | output | 1 | Address-latch-enable |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read/output-enable strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| rsp_done | output | 1 | One-clock pulse per completed word |
| rsp_err | output | 1 | One-clock pulse on an illegal sub-mode |
| rsp_rdata | output | DW | Captured read data |

## Verification
The bench drives each request in one clock and counts clocks from it. It expects the first rsp_done W+3 clocks later in the multiplexed sub-mode and W+2 clocks later in the separate sub-modes, and rsp_err exactly one clock later. Later done pulses follow each further word: one gap clock after each burst strobe, or in the first clock of the next continuous-read word. All outputs are sampled on the falling edge, so each result is read in the clock where the registered state puts it. The bench handles each done pulse before it checks that clock's strobe and address, and it changes req_burst and req_wdata at the same falling edge. Both are then stable before the rising edge that samples them.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [1:0] {
        MODE_MUX = 2'd0,
        MODE_SEP = 2'd1,
        MODE_CRD = 2'd2,
        MODE_BAD = 2'd3
    } hb_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_TURN = 3'd2,
        ST_STRB = 3'd3,
        ST_BGAP = 3'd4
    } hb_state_e;

endpackage

// File: rtl/hb_cfg_resolve.sv
// Chooses the effective sub-mode and the strobe length for a new request.
module hb_cfg_resolve
    import hb_seq_pkg::*;
#(
    parameter int WS_BITS   = 2,
    parameter int LEN_W     = 4,
    parameter int BURST_STB = 2
) (
    input  logic               cs_sel,
    input  logic [1:0]         cs_mode,
    input  logic [1:0]         glb_mode,
    input  logic               is_write,
    input  logic [WS_BITS-1:0] rd_ws,
    input  logic [WS_BITS-1:0] wr_ws,
    input  logic               rd_trim,
    input  logic               wr_trim,
    input  logic               burst_en,
    output hb_mode_e           mode,
    output logic               illegal,
    output logic               burst_go,
    output logic [LEN_W-1:0]   len
);

    logic [WS_BITS-1:0] ws_sel;
    logic               trim_sel;
    logic [LEN_W-1:0]   len_ws;

    always_comb begin
        mode     = hb_mode_e'(cs_sel ? cs_mode : glb_mode);
        illegal  = (mode == MODE_BAD);
        burst_go = burst_en && (mode == MODE_MUX);
        ws_sel   = is_write ? wr_ws : rd_ws;
        trim_sel = is_write ? wr_trim : rd_trim;
        // each encoding step is two clocks; the trim removes one
        len_ws   = ((LEN_W'(ws_sel) + LEN_W'(1)) << 1) - LEN_W'(trim_sel);
        len      = burst_go ? LEN_W'(BURST_STB) : len_ws;
    end

endmodule

// File: rtl/hb_strobe_timer.sv
// Counts clocks of an active strobe and flags its last clock.
module hb_strobe_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             last
);

    logic [LEN_W-1:0] cnt_q;

    assign last = run && (cnt_q == (len - LEN_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/hb_seq_fsm.sv
// Access state machine with its request and response registers.
module hb_seq_fsm
    import hb_seq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_burst,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  hb_mode_e         rs_mode,
    input  logic             rs_illegal,
    input  logic             rs_burst,
    input  logic [LEN_W-1:0] rs_len,
    input  logic [DW-1:0]    bus_ad_in,
    input  logic             tm_last,
    output logic             tm_run,
    output logic [LEN_W-1:0] len_q,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_ale,
    output logic             bus_cs,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata
);

    hb_state_e     state_q, state_d;
    hb_mode_e      mode_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          write_q;
    logic          burst_q;
    logic          crd_q;

    logic accept;
    logic word_end;
    logic go_burst;
    logic go_crd;

    assign accept   = (state_q == ST_IDLE) && req_valid && !rs_illegal;
    assign word_end = (state_q == ST_STRB) && tm_last;
    assign go_burst = word_end && req_burst && burst_q;
    assign go_crd   = word_end && req_burst && crd_q;
    assign tm_run   = (state_q == ST_STRB);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                state_d = (mode_q == MODE_MUX) ? ST_TURN : ST_STRB;
            end
            ST_TURN: begin
                state_d = ST_STRB;
            end
            ST_STRB: begin
                if (go_burst) begin
                    state_d = ST_BGAP;
                end else if (go_crd) begin
                    state_d = ST_STRB;
                end else if (tm_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BGAP: begin
                state_d = ST_STRB;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_MUX;
            addr_q    <= '0;
            wdata_q   <= '0;
            write_q   <= 1'b0;
            burst_q   <= 1'b0;
            crd_q     <= 1'b0;
            len_q     <= LEN_W'(1);
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= word_end;
            rsp_err  <= (state_q == ST_IDLE) && req_valid && rs_illegal;
            if (accept) begin
                mode_q  <= rs_mode;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                burst_q <= rs_burst;
                crd_q   <= (rs_mode == MODE_CRD) && !req_write;
                len_q   <= rs_len;
            end
            if (go_crd) begin
                addr_q <= addr_q + AW'(1);
            end
            if (state_q == ST_BGAP) begin
                wdata_q <= req_wdata;
            end
            if (word_end && !write_q) begin
                rsp_rdata <= bus_ad_in;
            end
        end
    end

    // pin outputs from the current state
    always_comb begin
        bus_cs     = 1'b0;
        bus_ale    = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_ad_oe  = 1'b0;
        bus_ad_out = '0;
        bus_addr   = '0;
        unique case (state_q)
            ST_IDLE: begin
                bus_cs = 1'b0;
            end
            ST_ADDR: begin
                bus_cs = 1'b1;
                if (mode_q == MODE_MUX) begin
                    bus_ale    = 1'b1;
                    bus_ad_oe  = 1'b1;
                    bus_ad_out = DW'(addr_q);
                end else begin
                    bus_addr   = addr_q;
                    bus_ad_oe  = write_q;
                    bus_ad_out = wdata_q;
                end
            end
            ST_TURN, ST_BGAP: begin
                bus_cs     = 1'b1;
                bus_ad_oe  = write_q;
                bus_ad_out = wdata_q;
            end
            ST_STRB: begin
                bus_cs     = 1'b1;
                bus_rd     = !write_q;
                bus_wr     = write_q;
                bus_ad_oe  = write_q;
                bus_ad_out = wdata_q;
                if (mode_q != MODE_MUX) begin
                    bus_addr = addr_q;
                end
            end
            default: begin
                bus_cs = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hb_strobe_seq.sv
// Top: one chip select of a 16-bit host bus.
module hb_strobe_seq
    import hb_seq_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 16,
    parameter int WS_BITS   = 2,
    parameter int BURST_STB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_burst,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic               cfg_cs_sel,
    input  logic [1:0]         cfg_cs_mode,
    input  logic [1:0]         cfg_glb_mode,
    input  logic [WS_BITS-1:0] cfg_rd_ws,
    input  logic [WS_BITS-1:0] cfg_wr_ws,
    input  logic               cfg_rd_trim,
    input  logic               cfg_wr_trim,
    input  logic               cfg_burst_en,
    input  logic [DW-1:0]      bus_ad_in,
    output logic [DW-1:0]      bus_ad_out,
    output logic               bus_ad_oe,
    output logic [AW-1:0]      bus_addr,
    output logic               bus_ale,
    output logic               bus_cs,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata
);

    localparam int MAX_LEN = 2 * (2 ** WS_BITS);
    localparam int LEN_W   = $clog2(((MAX_LEN > BURST_STB) ? MAX_LEN : BURST_STB) + 1);

    hb_mode_e         rs_mode;
    logic             rs_illegal;
    logic             rs_burst;
    logic [LEN_W-1:0] rs_len;
    logic [LEN_W-1:0] len_q;
    logic             tm_run;
    logic             tm_last;

    hb_cfg_resolve #(
        .WS_BITS  (WS_BITS),
        .LEN_W    (LEN_W),
        .BURST_STB(BURST_STB)
    ) u_resolve (
        .cs_sel  (cfg_cs_sel),
        .cs_mode (cfg_cs_mode),
        .glb_mode(cfg_glb_mode),
        .is_write(req_write),
        .rd_ws   (cfg_rd_ws),
        .wr_ws   (cfg_wr_ws),
        .rd_trim (cfg_rd_trim),
        .wr_trim (cfg_wr_trim),
        .burst_en(cfg_burst_en),
        .mode    (rs_mode),
        .illegal (rs_illegal),
        .burst_go(rs_burst),
        .len     (rs_len)
    );

    hb_strobe_timer #(
        .LEN_W(LEN_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tm_run),
        .len  (len_q),
        .last (tm_last)
    );

    hb_seq_fsm #(
        .DW   (DW),
        .AW   (AW),
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_burst (req_burst),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rs_mode   (rs_mode),
        .rs_illegal(rs_illegal),
        .rs_burst  (rs_burst),
        .rs_len    (rs_len),
        .bus_ad_in (bus_ad_in),
        .tm_last   (tm_last),
        .tm_run    (tm_run),
        .len_q     (len_q),
        .bus_ad_out(bus_ad_out),
        .bus_ad_oe (bus_ad_oe),
        .bus_addr  (bus_addr),
        .bus_ale   (bus_ale),
        .bus_cs    (bus_cs),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/hb_strobe_seq_chk.sv
module hb_strobe_seq_chk #(
    parameter int WS_BITS   = 2,
    parameter int BURST_STB = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bus_cs,
    input logic bus_ale,
    input logic bus_rd,
    input logic bus_wr,
    input logic rsp_done,
    input logic rsp_err
);

    localparam int MAXW = (2 * (2 ** WS_BITS) > BURST_STB) ? 2 * (2 ** WS_BITS) : BURST_STB;

    logic [7:0] wr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run <= '0;
        end else if (bus_wr) begin
            wr_run <= (wr_run == 8'hFF) ? wr_run : wr_run + 8'd1;
        end else begin
            wr_run <= '0;
        end
    end

    // R4: address-latch-enable is a single-clock pulse
    p_ale_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // R2 / R3: read and write strobes never overlap
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5: every strobe and latch pulse lies inside chip select
    p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr || bus_ale) |-> bus_cs);

    // R8: an error pulse comes with no bus cycle and no completion
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!bus_cs && !rsp_done));

    // R6: completion always follows a strobe clock
    p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_rd || bus_wr));

    // R3: a write strobe never exceeds the longest encoded width
    p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (wr_run < 8'(MAXW)));

endmodule

bind hb_strobe_seq hb_strobe_seq_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_cs  (bus_cs),
    .bus_ale (bus_ale),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .rsp_done(rsp_done),
    .rsp_err (rsp_err)
);

// File: tb/test_hb_strobe_seq.sv
`timescale 1ns/1ps
module test_hb_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        cfg_cs_sel = 1'b1;
    logic [1:0]  cfg_cs_mode = 2'd0, cfg_glb_mode = 2'd0;
    logic [1:0]  cfg_rd_ws = 2'd0, cfg_wr_ws = 2'd0;
    logic        cfg_rd_trim = 1'b0, cfg_wr_trim = 1'b0, cfg_burst_en = 1'b0;
    logic [15:0] bus_ad_in;
    logic [15:0] bus_ad_out, bus_addr, rsp_rdata;
    logic        bus_ad_oe, bus_ale, bus_cs, bus_rd, bus_wr, rsp_done, rsp_err;

    int checks = 0;
    int fails  = 0;
    int cur_mode = 0;
    logic [15:0] lat_addr = '0;
    logic [15:0] word_idx = '0;
    logic [15:0] wbuf [8];

    always #4 clk = ~clk;

    hb_strobe_seq i_hb_strobe_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_cs_sel(cfg_cs_sel), .cfg_cs_mode(cfg_cs_mode), .cfg_glb_mode(cfg_glb_mode),
        .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws),
        .cfg_rd_trim(cfg_rd_trim), .cfg_wr_trim(cfg_wr_trim), .cfg_burst_en(cfg_burst_en),
        .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_cs(bus_cs),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [15:0] dev_data(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // device model: latch the address on ALE, count words by done pulses
    always_ff @(posedge clk) begin
        if (bus_ale) begin
            lat_addr <= bus_ad_out;
            word_idx <= '0;
        end else if (rsp_done) begin
            word_idx <= word_idx + 16'd1;
        end
    end

    always_comb begin
        bus_ad_in = (cur_mode == 0) ? dev_data(lat_addr + word_idx) : dev_data(bus_addr);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    function automatic int exp_len(input bit wr, input bit burst);
        if (burst) return 2;
        if (wr) return 2 * (int'(cfg_wr_ws) + 1) - int'(cfg_wr_trim);
        return 2 * (int'(cfg_rd_ws) + 1) - int'(cfg_rd_trim);
    endfunction

    task automatic run_access(input bit wr, input logic [15:0] addr, input int nreq, input string tag);
        int  mode, nw, w, lat, k, n, rdhi, wrhi, rises, ales, first;
        bit  burst, crd, prd, pwr;
        mode = cfg_cs_sel ? int'(cfg_cs_mode) : int'(cfg_glb_mode);
        cur_mode = mode;
        if (mode == 3) begin
            // R8: illegal sub-mode
            @(negedge clk);
            req_valid = 1'b1; req_write = wr; req_addr = addr;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8", "err pulse", int'(rsp_err), 1);
            chk("R8", "cs during err", int'(bus_cs), 0);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R8", "no bus cycle", int'(bus_cs | rsp_done | rsp_err), 0);
            end
            return;
        end
        burst = (mode == 0) && cfg_burst_en;
        crd   = (mode == 2) && !wr;
        nw    = (burst || crd) ? nreq : 1;
        w     = exp_len(wr, burst);
        lat   = (mode == 0) ? w + 3 : w + 2;
        for (int i = 0; i < 8; i++) wbuf[i] = 16'($urandom);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = wbuf[0]; req_burst = (nw > 1);
        k = 0; n = 0; rdhi = 0; wrhi = 0; rises = 0; ales = 0; first = 1;
        prd = 1'b0; pwr = 1'b0;
        while (k < nw && n < 300) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (rsp_done) begin
                if (first == 1) begin
                    chk((mode == 0) ? "R4" : "R5", "first done latency", n, lat);
                    first = 0;
                end
                if (!wr) chk("R6", "read data", int'(rsp_rdata), int'(dev_data(16'(addr + 16'(k)))));
                k++;
                req_wdata = wbuf[k % 8];
                req_burst = (k + 1 < nw);
            end
            if (bus_rd) begin
                rdhi++;
                if (!prd) rises++;
                if (mode != 0) chk(crd ? "R7" : "R5", "read address", int'(bus_addr), int'(16'(addr + 16'(k))));
            end
            if (bus_wr) begin
                wrhi++;
                if (!pwr) rises++;
                chk(burst ? "R9" : "R3", "write data", int'(bus_ad_out), int'(wbuf[k % 8]));
                if (mode != 0) chk("R5", "write address", int'(bus_addr), int'(addr));
            end
            if (bus_ale) begin
                ales++;
                chk("R4", "ALE address", int'(bus_ad_out), int'(addr));
            end
            prd = bus_rd; pwr = bus_wr;
        end
        chk(tag, "words done", k, nw);
        chk(wr ? (burst ? "R9" : "R3") : (burst ? "R9" : "R2"), "strobe clocks", wr ? wrhi : rdhi, nw * w);
        chk(crd ? "R7" : "R9", "strobe pulses", rises, crd ? 1 : nw);
        chk((mode == 0) ? "R4" : "R5", "ALE pulses", ales, (mode == 0) ? 1 : 0);
        req_burst = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(tag, "idle after access", int'(bus_cs | rsp_done), 0);
        end
    endtask

    task automatic set_cfg(input bit sel, input int cm, input int gm, input int rws, input int wws,
                           input bit rt, input bit wt, input bit be);
        @(negedge clk);
        cfg_cs_sel = sel; cfg_cs_mode = 2'(cm); cfg_glb_mode = 2'(gm);
        cfg_rd_ws = 2'(rws); cfg_wr_ws = 2'(wws);
        cfg_rd_trim = rt; cfg_wr_trim = wt; cfg_burst_en = be;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "outputs in reset",
            int'({bus_cs, bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_done, rsp_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset",
            int'({bus_cs, bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_done, rsp_err}), 0);

        // R2 / R3: every wait-state encoding, with and without trim, multiplexed
        for (int e = 0; e < 4; e++) begin
            set_cfg(1, 0, 0, e, e, 0, 0, 0);
            run_access(0, 16'h1200 + 16'(e), 1, "R2");
            run_access(1, 16'h3400 + 16'(e), 1, "R3");
            set_cfg(1, 0, 0, e, e, 1, 1, 0);
            run_access(0, 16'h1280 + 16'(e), 1, "R2");
            run_access(1, 16'h3480 + 16'(e), 1, "R3");
        end
        // R5: separate lines, shortest and longest widths
        set_cfg(1, 1, 0, 0, 3, 1, 0, 1);
        run_access(0, 16'hBEEF, 1, "R5");
        run_access(1, 16'hCAFE, 1, "R5");
        // R7: continuous read with one-clock and eight-clock words, and a write in that mode
        set_cfg(1, 2, 0, 0, 1, 1, 0, 0);
        run_access(0, 16'h00FE, 3, "R7");
        set_cfg(1, 2, 0, 3, 1, 0, 0, 0);
        run_access(0, 16'hFFFE, 4, "R7");
        run_access(1, 16'h7000, 3, "R7");
        // R9: bursts in the multiplexed mode, wait states ignored
        set_cfg(1, 0, 0, 3, 3, 1, 1, 1);
        run_access(0, 16'h4000, 4, "R9");
        run_access(1, 16'h5000, 3, "R9");
        // R9: burst enable has no effect in the separate mode
        set_cfg(1, 1, 0, 1, 1, 0, 0, 1);
        run_access(0, 16'h6000, 3, "R9");
        // R8: illegal mode through both selectors
        set_cfg(1, 3, 0, 0, 0, 0, 0, 0);
        run_access(0, 16'h0001, 1, "R8");
        set_cfg(0, 0, 3, 0, 0, 0, 0, 0);
        run_access(1, 16'h0002, 1, "R8");
        // R10: global mode used when the chip-select enable is clear
        set_cfg(0, 3, 1, 1, 2, 0, 1, 0);
        run_access(0, 16'h9ABC, 1, "R10");
        run_access(1, 16'h9ABD, 1, "R10");
        set_cfg(0, 1, 0, 0, 0, 0, 0, 0);
        run_access(0, 16'h9AC0, 1, "R10");

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            set_cfg(1'($urandom), int'($urandom % 8) % 4, int'($urandom % 8) % 4 == 3 ? 3 : int'($urandom % 3),
                    int'($urandom % 4), int'($urandom % 4),
                    1'($urandom), 1'($urandom), 1'($urandom));
            run_access(1'($urandom), 16'($urandom), 1 + int'($urandom % 4), "R10");
        end

        summary();
        $finish;
    end

endmodule